// File: doc/BRIEF.md
# Memory-mapped UART with line control

A single-channel asynchronous serial port that a processor runs through a small synchronous register port. A 12-bit divisor sets a 16x sample tick, and that tick drives both the transmitter and the receiver. The frame format and FIFO mode live in a line register. Its settings, together with the divisor, reach the serial engines only when the port goes from disabled to enabled. The exception is the break bit, which acts at once.

Transmit and receive each have a FIFO of `DEPTH` entries, or a single holding entry when FIFO mode is off. Every received character keeps its own framing, parity and overrun status. Reading the data register pops the oldest character and latches that character's status into the status register. Read data is registered and appears the cycle after `reg_rd`. Two level interrupts report room in the transmit FIFO and data in the receive FIFO.

Register offsets: 0 data, 1 receive status, 2 divisor low, 3 divisor high nibble, 4 line, 5 control, 6 flags.

Top module: `mm_uart`

## Requirements
- R1: One serial bit lasts 16 × (D + 1) clock cycles. D is {offset 3 bits 3:0, offset 2 bits 7:0}.
- R2: A frame is sent in this order:
  - a low start bit;
  - the data bits, LSB first, with the count set by line bits 6:5 (00 = 5, 01 = 6, 10 = 7, 11 = 8);
  - a parity bit, only when line bit 1 is set; bit 2 set gives even parity and bit 2 clear gives odd parity;
  - one high stop bit, or two when line bit 3 is set.

  Between frames the line idles high.
- R3: The divisor and line bits 6:1 take effect only when the control register (offset 5) is written with bit 0 = 1 while the port is disabled. Control reads back 1 while the port is enabled and 0 after 0 is written.
- R4: Setting line bit 0 drives `ser_tx` low from the next cycle, whatever the transmitter is doing and with no commit needed. Clearing it releases the line.
- R5: The flags register (offset 6) reports:
  - bit 3: the transmitter holds data or is still shifting;
  - bit 4: the receive FIFO is empty;
  - bit 5: the transmit FIFO is full.

  All other bits read 0.
- R6: With line bit 4 set, each FIFO holds 16 characters in arrival order. A write to the data register (offset 0) while the transmit FIFO is full is dropped.
- R7: With line bit 4 clear, each direction holds a single character.
- R8: Reading offset 0 pops the oldest received character. Offset 1 then returns that character's status:
  - bit 0 is set when the stop bit was sampled low;
  - bit 1 is set when the parity check failed.
- R9: A character that arrives while the receive FIFO is full is dropped, and bit 2 (overrun) is set in the status of the last character held.
- R10: `irq_tx` is high while the transmit FIFO is not full. `irq_rx` is high while the receive FIFO is not empty.
- R11: After reset the port is disabled and `ser_tx` is high. Flags read 0x10, control reads 0, `irq_tx` is 1 and `irq_rx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the registers and the baud generation |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| irq_tx | output | 1 | Transmit FIFO has room |
| irq_rx | output | 1 | Receive FIFO holds data |

## Verification
Two functions can act in the same cycles: the break force and the transmit shifter. The bench raises break while a character is halfway through its frame, with loopback cut. It then requires `ser_tx` to stay low at every sample until break is cleared. Once break is released, the transmitter must finish its frame and go idle, and the next character must leave as a clean frame. The receive side has a second collision, a character that arrives into a full FIFO. The bench judges it by reading back all 16 held characters in order, with the overrun bit on the last one only.

// File: rtl/mm_uart.sv
module mm_uart #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       ser_tx,
  input  logic       ser_rx,
  output logic       irq_tx,
  output logic       irq_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_DLO = 3'd2, A_DMID = 3'd3,
                         A_LINE = 3'd4, A_CTRL = 3'd5, A_FLAG = 3'd6;

  logic        en;
  logic [7:0]  s_lo;
  logic [3:0]  s_mid;
  logic [6:0]  s_line;
  logic [11:0] a_div;
  logic [6:1]  a_line;

  wire       brk     = s_line[0];
  wire       a_par   = a_line[1];
  wire       a_even  = a_line[2];
  wire       a_stop2 = a_line[3];
  wire       a_fifo  = a_line[4];
  wire [1:0] a_len   = a_line[6:5];
  wire [3:0] nlen    = 4'd5 + {2'b0, a_len};
  wire [7:0] dmask   = 8'hFF >> (2'd3 - a_len);
  wire [CW-1:0] cap  = a_fifo ? CW'(DEPTH) : CW'(1);
  wire commit = reg_wr && reg_addr == A_CTRL && reg_wdata[0] && !en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; s_lo <= '0; s_mid <= '0; s_line <= '0; a_div <= '0; a_line <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DLO:  s_lo   <= reg_wdata;
        A_DMID: s_mid  <= reg_wdata[3:0];
        A_LINE: s_line <= reg_wdata[6:0];
        A_CTRL: begin
          en <= reg_wdata[0];
          if (commit) begin
            a_div  <= {s_mid, s_lo};
            a_line <= s_line[6:1];
          end
        end
        default: ;
      endcase
    end

  logic [11:0] bcnt;
  wire tick = en && bcnt == a_div;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= (!en || tick) ? 12'd0 : bcnt + 12'd1;

  logic [7:0]    txm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_act;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left, tx_sub;

  wire tx_full = tx_cnt >= cap;
  wire tx_push = reg_wr && reg_addr == A_DATA && !tx_full;
  wire tx_pop  = tick && !tx_act && tx_cnt != '0;

  always_ff @(posedge clk)
    if (tx_push) txm[tx_wp] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  logic [7:0]  tdat;
  logic [11:0] tframe;
  wire  [3:0]  tbits = nlen + 4'd2 + {3'b0, a_par} + {3'b0, a_stop2};
  always_comb begin
    tdat = txm[tx_rp] & dmask;
    tframe = '1;
    tframe[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nlen) tframe[i+1] = tdat[i];
    if (a_par) tframe[nlen+4'd1] = ^tdat ^ !a_even;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_act <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_sub <= '0; ser_tx <= 1'b1;
    end else begin
      ser_tx <= !brk && (!tx_act || tx_sh[0]);
      if (!en) tx_act <= 1'b0;
      else if (tick) begin
        if (tx_act) begin
          tx_sub <= tx_sub + 4'd1;
          if (tx_sub == 4'd15) begin
            tx_sh   <= {1'b1, tx_sh[11:1]};
            tx_left <= tx_left - 4'd1;
            if (tx_left == 4'd1) tx_act <= 1'b0;
          end
        end else if (tx_cnt != '0) begin
          tx_sh <= tframe; tx_left <= tbits; tx_sub <= '0; tx_act <= 1'b1;
        end
      end
    end

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rst_t;
  rst_t       rst;
  logic       rx_m, rx_s, rx_q, rx_done;
  logic [3:0] rsub, ridx;
  logic [9:0] rx_sh;
  wire  [3:0] nrx = nlen + {3'b0, a_par} + 4'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_q <= 1'b1; rx_done <= 1'b0;
      rst <= R_IDLE; rsub <= '0; ridx <= '0; rx_sh <= '0;
    end else begin
      rx_m <= ser_rx; rx_s <= rx_m; rx_q <= rx_s;
      rx_done <= 1'b0;
      if (!en) rst <= R_IDLE;
      else case (rst)
        R_IDLE: if (!rx_s && rx_q) begin rst <= R_START; rsub <= '0; end
        R_START: if (tick) begin
          rsub <= rsub + 4'd1;
          if (rsub == 4'd7) begin
            if (!rx_s) begin rst <= R_BITS; rsub <= '0; ridx <= '0; end
            else rst <= R_IDLE;
          end
        end
        R_BITS: if (tick) begin
          rsub <= rsub + 4'd1;
          if (rsub == 4'd15) begin
            rx_sh[ridx] <= rx_s;
            ridx <= ridx + 4'd1;
            if (ridx == nrx - 4'd1) begin rst <= R_IDLE; rx_done <= 1'b1; end
          end
        end
        default: rst <= R_IDLE;
      endcase
    end

  wire [7:0] rdat = rx_sh[7:0] & dmask;
  wire ferr = !rx_sh[nlen + {3'b0, a_par}];
  wire perr = a_par && (^rdat ^ rx_sh[nlen] ^ !a_even);

  logic [10:0]   rxm [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_stat;

  wire rx_full = rx_cnt >= cap;
  wire rx_pop  = reg_rd && reg_addr == A_DATA && rx_cnt != '0;
  wire rx_push = rx_done && (!rx_full || rx_pop);
  wire rx_ovr  = rx_done && !rx_push;

  always_ff @(posedge clk)
    if (rx_push)     rxm[rx_wp] <= {1'b0, perr, ferr, rdat};
    else if (rx_ovr) rxm[rx_wp - AW'(1)][10] <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  wire [7:0] flags = {2'b00, tx_full, rx_cnt == '0, tx_act || tx_cnt != '0, 3'b000};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_rdata <= '0; rx_stat <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_DATA: begin
          reg_rdata <= rx_pop ? rxm[rx_rp][7:0] : 8'h00;
          if (rx_pop) rx_stat <= rxm[rx_rp][10:8];
        end
        A_STAT:  reg_rdata <= {5'b0, rx_stat};
        A_DLO:   reg_rdata <= s_lo;
        A_DMID:  reg_rdata <= {4'b0, s_mid};
        A_LINE:  reg_rdata <= {1'b0, s_line};
        A_CTRL:  reg_rdata <= {7'b0, en};
        A_FLAG:  reg_rdata <= flags;
        default: reg_rdata <= 8'h00;
      endcase
    end

  assign irq_tx = !tx_full;
  assign irq_rx = rx_cnt != '0;
endmodule

// File: rtl/mm_uart_chk.sv
module mm_uart_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_tx,
  input logic          brk,
  input logic          tx_act,
  input logic          en,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_full,
  input logic          tx_pop,
  input logic          irq_rx,
  input logic          rx_push,
  input logic          commit,
  input logic [11:0]   a_div,
  input logic [7:0]    s_lo,
  input logic [3:0]    s_mid
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!brk && !tx_act) |=> ser_tx); // R2
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n) brk |=> !ser_tx); // R4
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (tx_full && !tx_pop) |=> tx_cnt == $past(tx_cnt)); // R6
  AST_COMMIT_DIV: assert property (@(posedge clk) disable iff (!rst_n) commit |=> a_div == $past({s_mid, s_lo})); // R3
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !tx_act); // R3
  AST_RXIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_rx) |-> $past(rx_push)); // R10
endmodule

bind mm_uart mm_uart_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/mm_uart_tb.sv
`timescale 1ns/1ps
module mm_uart_tb;
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_DLO = 3'd2, A_DMID = 3'd3,
                         A_LINE = 3'd4, A_CTRL = 3'd5, A_FLAG = 3'd6;
  localparam int NV = 5;
  // {div[11:0], line[7:0], data[7:0], nbits[3:0], frame[11:0], rx_expect[7:0]}
  localparam logic [51:0] VEC [NV] = '{
    {12'd0, 8'h70, 8'hA5, 4'd10, 12'h34A, 8'hA5},
    {12'd2, 8'h76, 8'h03, 4'd11, 12'h406, 8'h03},
    {12'd1, 8'h12, 8'hFF, 4'd8,  12'h0BE, 8'h1F},
    {12'd0, 8'h58, 8'h41, 4'd10, 12'h382, 8'h41},
    {12'd0, 8'h2E, 8'h2B, 4'd10, 12'h356, 8'h2B}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ser_tx, irq_tx, irq_rx;
  logic inj = 1'b0, inj_v = 1'b1;
  wire  ser_rx = inj ? inj_v : ser_tx;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mm_uart u_dut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
                 .ser_tx, .ser_rx, .irq_tx, .irq_rx);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic setup(logic [11:0] dv, logic [7:0] ln);
    wr(A_CTRL, 8'h00); wr(A_DLO, dv[7:0]); wr(A_DMID, {4'h0, dv[11:8]});
    wr(A_LINE, ln); wr(A_CTRL, 8'h01);
  endtask

  task automatic capture(logic [11:0] dv, int nb, output logic [11:0] f);
    int bitc;
    bitc = 16 * (int'(dv) + 1);
    f = '0;
    @(negedge ser_tx);
    repeat (bitc / 2) @(posedge clk);
    #2 f[0] = ser_tx;
    for (int i = 1; i < nb; i++) begin
      repeat (bitc) @(posedge clk);
      #2 f[i] = ser_tx;
    end
  endtask

  task automatic send_raw(int nb, logic [11:0] f);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); inj_v = f[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); inj_v = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [11:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(A_FLAG, d); chk("R11 flags", d, 8'h10);
    rd(A_CTRL, d); chk("R11 ctrl", d, 8'h00);
    chk("R11 ser_tx", ser_tx, 1'b1);
    chk("R11 irq_tx", irq_tx, 1'b1);
    chk("R11 irq_rx", irq_rx, 1'b0);

    // R1 R2 R8: frame vectors over loopback
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][51:40], VEC[v][39:32]);
      wr(A_DATA, VEC[v][31:24]);
      capture(VEC[v][51:40], int'(VEC[v][23:20]), f);
      chk($sformatf("R1 R2 frame vec%0d", v), f, VEC[v][19:8]);
      repeat (16 * (int'(VEC[v][51:40]) + 1) * 2) @(posedge clk);
      rd(A_DATA, d); chk($sformatf("R8 rx data vec%0d", v), d, VEC[v][7:0]);
      rd(A_STAT, d); chk($sformatf("R8 rx status vec%0d", v), d, 8'h00);
    end

    // R3 control readback and commit-on-enable
    setup(12'd0, 8'h70);
    rd(A_CTRL, d); chk("R3 ctrl enabled", d, 8'h01);
    wr(A_LINE, 8'h00); wr(A_DLO, 8'h05);
    wr(A_DATA, 8'hA5);
    capture(12'd0, 10, f); chk("R3 uncommitted config ignored", f, 12'h34A);
    repeat (200) @(posedge clk);
    rd(A_DATA, d); chk("R3 rx under old config", d, 8'hA5);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, d); chk("R3 ctrl disabled", d, 8'h00);
    setup(12'd0, 8'h70);

    // R5 busy flag
    wr(A_DATA, 8'h66);
    rd(A_FLAG, d); chk("R5 busy flags", d, 8'h18);
    repeat (300) @(posedge clk);
    rd(A_FLAG, d); chk("R5 idle with rx data", d, 8'h00);
    rd(A_DATA, d); chk("R8 busy char", d, 8'h66);

    // R4 break during a frame, loopback cut
    inj = 1'b1; inj_v = 1'b1;
    wr(A_DATA, 8'h55);
    repeat (40) @(posedge clk);
    wr(A_LINE, 8'h71);
    for (int k = 0; k < 5; k++) begin
      repeat (30) @(posedge clk);
      #2 chk("R4 break holds low", ser_tx, 1'b0);
    end
    wr(A_LINE, 8'h70);
    d = 8'hFF;
    for (int k = 0; k < 60 && d[3]; k++) rd(A_FLAG, d);
    chk("R4 released line idle", ser_tx, 1'b1);
    inj = 1'b0;
    wr(A_DATA, 8'h3C);
    capture(12'd0, 10, f); chk("R4 R2 clean frame after break", f, 12'h278);
    repeat (200) @(posedge clk);
    rd(A_DATA, d); chk("R8 char after break", d, 8'h3C);

    // R6 R9 R10 full FIFOs and overrun
    wr(A_CTRL, 8'h00);
    for (int i = 0; i < 17; i++) wr(A_DATA, 8'h10 + 8'(i));
    rd(A_FLAG, d); chk("R6 R5 tx full flags", d, 8'h38);
    chk("R10 irq_tx low when full", irq_tx, 1'b0);
    wr(A_CTRL, 8'h01);
    repeat (3200) @(posedge clk);
    chk("R10 irq_rx high", irq_rx, 1'b1);
    chk("R10 irq_tx high after drain", irq_tx, 1'b1);
    wr(A_DATA, 8'h99);
    repeat (250) @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, d); chk($sformatf("R6 order %0d", i), d, 8'h10 + 8'(i));
      rd(A_STAT, d); chk($sformatf("R9 status %0d", i), d, (i == 15) ? 8'h04 : 8'h00);
    end
    rd(A_FLAG, d); chk("R9 R6 dropped chars absent", d, 8'h10);
    chk("R10 irq_rx low when empty", irq_rx, 1'b0);

    // R7 single-entry mode
    setup(12'd0, 8'h60);
    wr(A_CTRL, 8'h00);
    wr(A_DATA, 8'h81);
    rd(A_FLAG, d); chk("R7 full after one", d, 8'h38);
    wr(A_DATA, 8'h82);
    wr(A_CTRL, 8'h01);
    repeat (500) @(posedge clk);
    rd(A_FLAG, d); chk("R7 rx holds one", d, 8'h00);
    rd(A_DATA, d); chk("R7 first char kept", d, 8'h81);
    rd(A_FLAG, d); chk("R7 second write dropped", d, 8'h10);

    // R8 framing and parity errors by injection
    setup(12'd0, 8'h70);
    inj = 1'b1;
    send_raw(10, 12'h0B4);
    repeat (60) @(posedge clk);
    rd(A_DATA, d); chk("R8 framing data", d, 8'h5A);
    rd(A_STAT, d); chk("R8 framing status", d, 8'h01);
    setup(12'd0, 8'h76);
    send_raw(11, 12'h606);
    repeat (60) @(posedge clk);
    rd(A_DATA, d); chk("R8 parity data", d, 8'h03);
    rd(A_STAT, d); chk("R8 parity status", d, 8'h02);
    inj = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule